// File: doc/BRIEF.md
# Distributed Pipeline Stage Flow Controller

This block is the flow-control skeleton of an in-order pipeline. It has no central controller. Each stage has its own small controller with three states: idle, working, or stalled on a finished result. A controller sees only its own status and three conditions. The first is whether its downstream neighbour will take a result. The second is whether its upstream neighbour offers one. The third is whether the current cycle ends its own work. A stage that has finished raises a data-available signal toward the next stage, and that stage answers with an accept. An instruction, carried as an opaque tag, moves across a boundary only in a cycle where both are true.

Work in a stage can last several cycles. The length is presented per stage and captured when an instruction enters. While a long operation runs, the stages behind it fill up and stall. The stages after it drain and go idle.

A separate exception collector watches a fault flag from every stage and honours a flag only from a stage that holds an instruction. The oldest faulting instruction is the one furthest downstream. The collector quashes it together with every younger instruction behind it, so the exception stays precise. One cycle later it raises a redirect pulse that starts the handler fetch. Stages ahead of the fault are not disturbed.

Top module: `pfc_top`

## Requirements
- R1: After reset every stage reports idle (state code 0), out_valid and redirect are low and in_ready is high.
- R2: stage_state carries two bits per stage, stage i at bits [2i+1:2i], coded idle = 0, working = 1, stalled = 2.
- R3: An instruction entering a stage with length n stays in that stage's working state for n cycles. A length of 0 counts as 1. The stage is done only in its last working cycle.
- R4: A tag moves from one stage to the next, or leaves at out_tag, only in a cycle where the sender is done and the receiver accepts. The tag arrives unchanged.
- R5: A done stage whose receiver refuses enters the stalled state. It holds its tag until the receiver accepts.
- R6: While a middle stage performs multicycle work, the stages behind it that cannot hand off end up stalled, and the stages after it go idle.
- R7: Without faults, tags leave in the order they entered. Each tag leaves exactly once, under any mix of work lengths and output back-pressure.
- R8: A fault from an occupied stage k sends stages 0 to k to idle on the next cycle. The tags held there never leave. Stages above k keep their work.
- R9: When several occupied stages fault in the same cycle, the highest-numbered one wins. Its quash covers all the others.
- R10: redirect is high for exactly one cycle, the cycle after an honoured fault. A fault flag from an idle stage is ignored.
- R11: in_ready is high when stage 0 is idle. It is low when stage 0 is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is offered to stage 0 |
| in_tag | input | TAGW | Tag of the offered instruction |
| in_ready | output | 1 | Stage 0 takes the offered instruction this cycle |
| stage_len | input | NSTAGE*LENW | Work length per stage, stage i at [i*LENW +: LENW] |
| stage_fault | input | NSTAGE | Fault flag per stage |
| out_valid | output | 1 | Last stage has a finished instruction |
| out_tag | output | TAGW | Tag of the finished instruction |
| out_accept | input | 1 | Downstream takes the finished instruction |
| redirect | output | 1 | One-cycle handler fetch pulse |
| stage_state | output | 2*NSTAGE | State code of each stage |

## Verification
An offer accepted at a clock edge shows stage 0 working right after that edge. With the default length each further stage is reached one edge later. A length-n stage is seen working for n samples before the tag moves on, so each check is placed a counted number of falling edges after the edge that caused it.

A fault presented before an edge shows its quashed stages idle, and redirect high, right after that edge. Redirect is low again after the following edge.

Inputs change on falling edges. The output handshake is logged shortly after each falling edge, when it is certain to complete at the next rising edge. The logged tags are compared with the list of tags pushed, minus those that were quashed.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WORK  = 2'd1,
    ST_STALL = 2'd2
  } stage_st_e;
endpackage

// File: rtl/pfc_rst_sync.sv
module pfc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pfc_stage.sv
module pfc_stage
  import pfc_pkg::*;
#(
  parameter int TAGW = 8,
  parameter int LENW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            up_avail,
  input  logic [TAGW-1:0] up_tag,
  input  logic            dn_accept,
  input  logic [LENW-1:0] len,
  input  logic            quash,
  output stage_st_e       st,
  output logic            done,
  output logic            acc_up,
  output logic [TAGW-1:0] tag
);
  stage_st_e       st_q, st_n;
  logic [LENW-1:0] cnt_q, cnt_n;
  logic [TAGW-1:0] tag_q;
  logic            last, done_raw, take, cnt_en;

  assign last     = (cnt_q <= LENW'(1));
  assign done_raw = ((st_q == ST_WORK) && last) || (st_q == ST_STALL);
  assign done     = done_raw && !quash;
  assign acc_up   = !quash && ((st_q == ST_IDLE) || (done_raw && dn_accept));
  assign take     = up_avail && acc_up;

  always_comb begin
    st_n = st_q;
    if (quash) begin
      st_n = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:  st_n = take ? ST_WORK : ST_IDLE;
        ST_WORK: begin
          if (!last)          st_n = ST_WORK;
          else if (dn_accept) st_n = take ? ST_WORK : ST_IDLE;
          else                st_n = ST_STALL;
        end
        ST_STALL: begin
          if (dn_accept) st_n = take ? ST_WORK : ST_IDLE;
          else           st_n = ST_STALL;
        end
        default:  st_n = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_n  = cnt_q;
    if (take) begin
      cnt_en = 1'b1;
      cnt_n  = (len == '0) ? LENW'(1) : len;
    end else if (st_q == ST_WORK && !last) begin
      cnt_en = 1'b1;
      cnt_n  = cnt_q - LENW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      tag_q <= '0;
    end else begin
      st_q <= st_n;
      if (cnt_en) cnt_q <= cnt_n;
      if (take)   tag_q <= up_tag;
    end
  end

  assign st  = st_q;
  assign tag = tag_q;

  assert_quash_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    quash |=> st_q == ST_IDLE);

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STALL && !dn_accept && !quash) |=> (st_q == ST_STALL && $stable(tag_q)));

  assert_work_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WORK && !last && !quash) |=> (st_q == ST_WORK && cnt_q == $past(cnt_q) - LENW'(1)));

  assert_take_when_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && st_q != ST_IDLE) |-> (done_raw && dn_accept));
endmodule

// File: rtl/pfc_exc.sv
module pfc_exc #(
  parameter int NSTAGE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSTAGE-1:0] fault,
  input  logic [NSTAGE-1:0] active,
  output logic [NSTAGE-1:0] quash,
  output logic              redirect
);
  localparam int IW = (NSTAGE > 1) ? $clog2(NSTAGE) : 1;

  logic [NSTAGE-1:0] live;
  logic [IW-1:0]     win;
  logic              hit;
  logic              redir_q;

  assign live = fault & active;
  assign hit  = |live;

  always_comb begin
    win = '0;
    for (int i = 0; i < NSTAGE; i++) begin
      if (live[i]) win = IW'(i);
    end
  end

  always_comb begin
    for (int i = 0; i < NSTAGE; i++) begin
      quash[i] = hit && (IW'(i) <= win);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) redir_q <= 1'b0;
    else        redir_q <= hit;
  end

  assign redirect = redir_q;

  generate
    for (genvar g = 1; g < NSTAGE; g++) begin : g_prefix
      assert_quash_prefix_R9: assert property (@(posedge clk) disable iff (!rst_n)
        quash[g] |-> quash[g-1]);
      assert_oldest_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        live[g] |-> quash[g]);
    end
  endgenerate

  assert_idle_fault_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |-> (quash == '0));
endmodule

// File: rtl/pfc_top.sv
module pfc_top
  import pfc_pkg::*;
#(
  parameter int NSTAGE = 4,
  parameter int TAGW   = 8,
  parameter int LENW   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [TAGW-1:0]        in_tag,
  output logic                   in_ready,
  input  logic [NSTAGE*LENW-1:0] stage_len,
  input  logic [NSTAGE-1:0]      stage_fault,
  output logic                   out_valid,
  output logic [TAGW-1:0]        out_tag,
  input  logic                   out_accept,
  output logic                   redirect,
  output logic [2*NSTAGE-1:0]    stage_state
);
  logic              rst_n_s;
  logic [NSTAGE-1:0] active, quash;

  pfc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  generate
    for (genvar i = 0; i < NSTAGE; i++) begin : stg
      logic            avail_w, dn_acc_w, done_w, acc_w;
      logic [TAGW-1:0] in_tag_w, tag_w;
      stage_st_e       st_w;

      if (i == 0) begin : g_head
        assign avail_w  = in_valid;
        assign in_tag_w = in_tag;
      end else begin : g_body
        assign avail_w  = stg[i-1].done_w;
        assign in_tag_w = stg[i-1].tag_w;
      end

      if (i == NSTAGE-1) begin : g_tail
        assign dn_acc_w = out_accept;
      end else begin : g_mid
        assign dn_acc_w = stg[i+1].acc_w;
      end

      pfc_stage #(.TAGW(TAGW), .LENW(LENW)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n_s),
        .up_avail (avail_w),
        .up_tag   (in_tag_w),
        .dn_accept(dn_acc_w),
        .len      (stage_len[i*LENW +: LENW]),
        .quash    (quash[i]),
        .st       (st_w),
        .done     (done_w),
        .acc_up   (acc_w),
        .tag      (tag_w)
      );

      assign active[i]          = (st_w != ST_IDLE);
      assign stage_state[2*i +: 2] = st_w;
    end
  endgenerate

  pfc_exc #(.NSTAGE(NSTAGE)) u_exc (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .fault   (stage_fault),
    .active  (active),
    .quash   (quash),
    .redirect(redirect)
  );

  assign in_ready  = stg[0].acc_w;
  assign out_valid = stg[NSTAGE-1].done_w;
  assign out_tag   = stg[NSTAGE-1].tag_w;

  assert_redirect_cause_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    redirect |-> $past(|quash));

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && !out_accept && !quash[NSTAGE-1]) |=> (out_valid && $stable(out_tag)));
endmodule

// File: tb/tb_pfc_top.sv
`timescale 1ns/1ps
module tb_pfc_top;
  localparam int NSTAGE = 4;
  localparam int TAGW   = 8;
  localparam int LENW   = 4;

  logic                   clk;
  logic                   rst_n;
  logic                   in_valid;
  logic [TAGW-1:0]        in_tag;
  logic                   in_ready;
  logic [NSTAGE*LENW-1:0] stage_len;
  logic [NSTAGE-1:0]      stage_fault;
  logic                   out_valid;
  logic [TAGW-1:0]        out_tag;
  logic                   out_accept;
  logic                   redirect;
  logic [2*NSTAGE-1:0]    stage_state;

  int checks = 0;
  int errors = 0;
  int next_tag = 1;
  bit rnd_on = 0;
  bit done_flag = 0;
  int out_log[$];

  pfc_top #(.NSTAGE(NSTAGE), .TAGW(TAGW), .LENW(LENW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .in_ready(in_ready), .stage_len(stage_len), .stage_fault(stage_fault),
    .out_valid(out_valid), .out_tag(out_tag), .out_accept(out_accept),
    .redirect(redirect), .stage_state(stage_state)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    #1;
    if (out_valid && out_accept) out_log.push_back(int'(out_tag));
  end

  always @(negedge clk) begin
    if (rnd_on) begin
      out_accept = 1'($urandom % 2);
      for (int i = 0; i < NSTAGE; i++) stage_len[i*LENW +: LENW] = LENW'($urandom % 4);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int st_of(input int i);
    return int'(stage_state[2*i +: 2]);
  endfunction

  task automatic set_lens(input int l0, input int l1, input int l2, input int l3);
    stage_len = {LENW'(l3), LENW'(l2), LENW'(l1), LENW'(l0)};
  endtask

  task automatic push(output int t);
    t = next_tag;
    next_tag++;
    @(negedge clk);
    in_valid = 1'b1;
    in_tag   = TAGW'(t);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic end_push();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    out_accept = 1'b1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (stage_state == '0) break;
    end
    @(negedge clk);
    #2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_tag = '0; out_accept = 1'b1;
    stage_fault = '0; set_lens(1, 1, 1, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(stage_state == '0, "R1 states idle", int'(stage_state), 0);
    chk(!out_valid && !redirect, "R1 out_valid/redirect low", int'({out_valid, redirect}), 0);
    chk(in_ready, "R1 in_ready high", int'(in_ready), 1);
  endtask

  task automatic t_basic();
    int base, t;
    base = out_log.size();
    for (int k = 0; k < 5; k++) push(t);
    end_push();
    drain();
    chk(out_log.size() - base == 5, "R4 basic count", out_log.size() - base, 5);
    for (int k = 0; k < 5; k++)
      if (base + k < out_log.size())
        chk(out_log[base + k] == t - 4 + k, "R4 basic tag", out_log[base + k], t - 4 + k);
  endtask

  task automatic t_len();
    int t;
    set_lens(1, 3, 1, 1);
    push(t);
    end_push();
    chk(st_of(0) == 1, "R2 stage0 working code", st_of(0), 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(st_of(1) == 1, "R3 stage1 busy", st_of(1), 1);
    end
    @(negedge clk);
    chk(st_of(1) == 0 && st_of(2) == 1, "R3 leaves after 3", st_of(1) * 4 + st_of(2), 1);
    drain();
    chk(out_log[$] == t, "R3 tag out", out_log[$], t);
    set_lens(0, 0, 0, 0);
    push(t);
    end_push();
    @(negedge clk);
    chk(st_of(0) == 0 && st_of(1) == 1, "R3 zero length acts as one", st_of(0) * 4 + st_of(1), 1);
    drain();
    set_lens(1, 1, 1, 1);
  endtask

  task automatic t_backpressure();
    int base, t;
    base = out_log.size();
    out_accept = 1'b0;
    for (int k = 0; k < 4; k++) push(t);
    end_push();
    repeat (3) @(negedge clk);
    #1;
    chk(stage_state == 8'b10101010, "R5 all stalled", int'(stage_state), 8'hAA);
    chk(!in_ready, "R11 in_ready low when stage0 stalled", int'(in_ready), 0);
    chk(out_valid && int'(out_tag) == t - 3, "R5 held tag", int'(out_tag), t - 3);
    @(negedge clk);
    #1;
    chk(int'(out_tag) == t - 3, "R5 tag stable", int'(out_tag), t - 3);
    drain();
    chk(out_log.size() - base == 4, "R5 none lost", out_log.size() - base, 4);
    chk(in_ready, "R11 in_ready high when idle", int'(in_ready), 1);
  endtask

  task automatic t_mid();
    int t;
    set_lens(1, 1, 6, 1);
    for (int k = 0; k < 3; k++) push(t);
    end_push();
    repeat (2) @(negedge clk);
    chk(st_of(0) == 2 && st_of(1) == 2, "R6 behind stalled", st_of(0) * 4 + st_of(1), 10);
    chk(st_of(2) == 1 && st_of(3) == 0, "R6 ahead idle", st_of(2) * 4 + st_of(3), 4);
    drain();
    set_lens(1, 1, 1, 1);
  endtask

  task automatic fill(output int first);
    int t;
    set_lens(1, 1, 1, 8);
    push(first);
    for (int k = 0; k < 3; k++) push(t);
    end_push();
    @(negedge clk);
    chk(stage_state == 8'b01101010, "R8 filled", int'(stage_state), 8'h6A);
  endtask

  task automatic t_fault();
    int base, a;
    base = out_log.size();
    fill(a);
    stage_fault = 4'b0010;
    @(negedge clk);
    stage_fault = '0;
    chk(st_of(0) == 0 && st_of(1) == 0, "R8 young quashed", st_of(0) * 4 + st_of(1), 0);
    chk(st_of(2) == 2 && st_of(3) == 1, "R8 older kept", st_of(2) * 4 + st_of(3), 9);
    chk(redirect, "R10 redirect pulse", int'(redirect), 1);
    @(negedge clk);
    chk(!redirect, "R10 redirect one cycle", int'(redirect), 0);
    drain();
    chk(out_log.size() - base == 2, "R8 count", out_log.size() - base, 2);
    if (out_log.size() - base == 2) begin
      chk(out_log[base] == a, "R8 first", out_log[base], a);
      chk(out_log[base + 1] == a + 1, "R8 second", out_log[base + 1], a + 1);
    end
  endtask

  task automatic t_multi();
    int base, a;
    base = out_log.size();
    fill(a);
    stage_fault = 4'b0101;
    @(negedge clk);
    stage_fault = '0;
    chk(stage_state == 8'b01000000, "R9 oldest wins", int'(stage_state), 8'h40);
    drain();
    chk(out_log.size() - base == 1 && out_log[$] == a, "R9 only oldest leaves", out_log[$], a);
    stage_fault = 4'b1000;
    @(negedge clk);
    stage_fault = '0;
    chk(!redirect && stage_state == '0, "R10 idle fault ignored", int'(redirect), 0);
  endtask

  task automatic t_random();
    int base, first, t;
    base = out_log.size();
    first = next_tag;
    rnd_on = 1;
    for (int k = 0; k < 40; k++) push(t);
    end_push();
    rnd_on = 0;
    drain();
    chk(out_log.size() - base == 40, "R7 random count", out_log.size() - base, 40);
    for (int k = 0; k < 40; k++)
      if (base + k < out_log.size() && out_log[base + k] != first + k)
        chk(0, "R7 random order", out_log[base + k], first + k);
    chk(1, "R7 order scan", 0, 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    t_reset();
    t_basic();
    t_len();
    t_backpressure();
    t_mid();
    t_fault();
    t_multi();
    t_random();
    finish_run();
  end
endmodule